// File: doc/BRIEF.md
# Storage Key Checker

This block guards a small physical memory that is split into fixed 2048-byte blocks. Each block carries a 4-bit tag and a fetch-protect flag. Every memory request arrives with a physical address, a read/write flag and the processor status word. The 4-bit access key held in that status word is compared with the tag of the addressed block. The block then grants the access or reports an exception. A denied store never reaches memory: the store-enable output stays low.

Tags change only through two supervisor operations. One writes the tag and fetch-protect flag of a block. The other returns them. Either operation issued without supervisor rights is refused, and the tag array is left as it was. Addresses beyond the covered range are refused on both paths.

Top module: `skey_guard`

## Requirements
- R1: After reset every block tag is 0 with fetch-protect clear, and `rsp_valid`, `mem_we` and `op_ack` are low.
- R2: A request whose access key equals the block tag is granted with `rsp_err` = 0 (none); a granted store raises `mem_we`.
- R3: A request is granted when the access key is 0 or the block tag is 0, whatever the other key holds.
- R4: A store with nonzero, unequal keys gets `rsp_err` = 1 (protection), `rsp_grant` low and `mem_we` low.
- R5: A read of a block whose fetch-protect flag is clear is granted for any access key, and never raises `mem_we`.
- R6: A read of a block whose fetch-protect flag is set is checked like a store: a mismatch gives `rsp_err` = 1, and a match is granted.
- R7: The access key is taken from bits [11:8] of `req_psw`; all other status bits have no effect on the decision.
- R8: Address bits [16:11] select the block, so all 2048 bytes of a block share one tag and the next block is checked against its own tag.
- R9: An address with any bit above bit 16 set gets error code 2 (addressing) on either path: a request is refused without `mem_we`, and a set operation leaves the array unchanged.
- R10: A set or insert operation with `op_super` low returns `op_err` = 3 (privileged), returns zero data and leaves the array unchanged.
- R11: A supervisor set (`op_set`=1) stores `op_key` and `op_fetch_prot` into the block. A supervisor insert (`op_set`=0) returns that block's tag and flag on `op_key_out` and `op_fetch_prot_out`.
- R12: Each request or operation is answered on the clock edge after the one that samples it, with a single-cycle `rsp_valid` or `op_ack` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Memory request present |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | ADDR_W | Physical byte address of the request |
| req_psw | input | PSW_W | Processor status word carrying the access key |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 1 | Access allowed |
| rsp_err | output | 2 | 0 none, 1 protection, 2 addressing |
| mem_we | output | 1 | Store enable toward memory; low for any denied store |
| op_valid | input | 1 | Supervisor operation present |
| op_set | input | 1 | 1 = set tag, 0 = insert (read) tag |
| op_super | input | 1 | Issuer holds supervisor rights |
| op_addr | input | ADDR_W | Address of the block the operation targets |
| op_key | input | 4 | Tag to write on set |
| op_fetch_prot | input | 1 | Fetch-protect flag to write on set |
| op_ack | output | 1 | Operation completed |
| op_err | output | 2 | 0 none, 2 addressing, 3 privileged |
| op_key_out | output | 4 | Tag returned by insert |
| op_fetch_prot_out | output | 1 | Fetch-protect flag returned by insert |

## Verification
The compare is driven with equal nonzero keys, a zero access key against a tagged block, a nonzero key against an untagged block, and unequal nonzero keys. These separate a plain equality check from the wildcard rule. Reads are sent to the same block before and after fetch-protect is set, which shows whether the flag, and not the read/write bit alone, decides when reads are checked. Status words with junk outside bits [11:8], addresses at both ends of one block and in its neighbour, and out-of-range addresses pin down the key field, the block index and the range check. Refused supervisor operations are each followed by an insert, which shows that the array was left untouched.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int KEY_W = 4;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_PROT = 2'd1,
    ERR_ADDR = 2'd2,
    ERR_PRIV = 2'd3
  } err_e;

  typedef struct packed {
    logic             fetch_prot;
    logic [KEY_W-1:0] key;
  } tag_t;
endpackage

// File: rtl/skey_table.sv
module skey_table
  import skey_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int N_BLK = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tag_t             wr_tag,
  input  logic [IDX_W-1:0] rd_a_idx,
  output tag_t             rd_a_tag,
  input  logic [IDX_W-1:0] rd_b_idx,
  output tag_t             rd_b_tag
);
  tag_t mem [N_BLK];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_BLK; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_tag;
    end
  end

  assign rd_a_tag = mem[rd_a_idx];
  assign rd_b_tag = mem[rd_b_idx];
endmodule

// File: rtl/skey_match.sv
module skey_match
  import skey_pkg::*;
(
  input  tag_t             blk,
  input  logic [KEY_W-1:0] cur_key,
  input  logic             is_store,
  output logic             pass
);
  logic keys_ok;

  always_comb begin
    keys_ok = (cur_key == '0) || (blk.key == '0) || (cur_key == blk.key);
    pass    = (is_store || blk.fetch_prot) ? keys_ok : 1'b1;
  end
endmodule

// File: rtl/skey_guard.sv
module skey_guard
  import skey_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int BLK_LSB     = 11,
  parameter int IDX_W       = 6,
  parameter int PSW_W       = 16,
  parameter int PSW_KEY_LSB = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PSW_W-1:0]  req_psw,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [1:0]        rsp_err,
  output logic              mem_we,
  input  logic              op_valid,
  input  logic              op_set,
  input  logic              op_super,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [3:0]        op_key,
  input  logic              op_fetch_prot,
  output logic              op_ack,
  output logic [1:0]        op_err,
  output logic [3:0]        op_key_out,
  output logic              op_fetch_prot_out
);
  localparam int HI_LSB = BLK_LSB + IDX_W;

  logic [IDX_W-1:0] req_idx, op_idx;
  logic             req_out_of_range, op_out_of_range;
  logic [KEY_W-1:0] cur_key;
  tag_t             req_tag, op_tag;
  logic             key_pass;
  logic             tbl_wr;
  tag_t             new_tag;

  assign req_idx = req_addr[BLK_LSB +: IDX_W];
  assign op_idx  = op_addr[BLK_LSB +: IDX_W];
  assign cur_key = req_psw[PSW_KEY_LSB +: KEY_W];

  generate
    if (ADDR_W > HI_LSB) begin : g_range
      assign req_out_of_range = |req_addr[ADDR_W-1:HI_LSB];
      assign op_out_of_range  = |op_addr[ADDR_W-1:HI_LSB];
    end else begin : g_full
      assign req_out_of_range = 1'b0;
      assign op_out_of_range  = 1'b0;
    end
  endgenerate

  assign new_tag.key        = op_key;
  assign new_tag.fetch_prot = op_fetch_prot;
  assign tbl_wr = op_valid && op_set && op_super && !op_out_of_range;

  skey_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (tbl_wr),
    .wr_idx   (op_idx),
    .wr_tag   (new_tag),
    .rd_a_idx (req_idx),
    .rd_a_tag (req_tag),
    .rd_b_idx (op_idx),
    .rd_b_tag (op_tag)
  );

  skey_match u_match (
    .blk      (req_tag),
    .cur_key  (cur_key),
    .is_store (req_write),
    .pass     (key_pass)
  );

  err_e req_err_n, op_err_n;

  always_comb begin
    if (req_out_of_range)  req_err_n = ERR_ADDR;
    else if (!key_pass)    req_err_n = ERR_PROT;
    else                   req_err_n = ERR_NONE;
    if (!op_super)         op_err_n = ERR_PRIV;
    else if (op_out_of_range) op_err_n = ERR_ADDR;
    else                   op_err_n = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid         <= 1'b0;
      rsp_grant         <= 1'b0;
      rsp_err           <= ERR_NONE;
      mem_we            <= 1'b0;
      op_ack            <= 1'b0;
      op_err            <= ERR_NONE;
      op_key_out        <= '0;
      op_fetch_prot_out <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && (req_err_n == ERR_NONE);
      rsp_err   <= req_valid ? req_err_n : ERR_NONE;
      mem_we    <= req_valid && req_write && (req_err_n == ERR_NONE);
      op_ack    <= op_valid;
      op_err    <= op_valid ? op_err_n : ERR_NONE;
      if (op_valid && !op_set && op_err_n == ERR_NONE) begin
        op_key_out        <= op_tag.key;
        op_fetch_prot_out <= op_tag.fetch_prot;
      end else begin
        op_key_out        <= '0;
        op_fetch_prot_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/skey_guard_chk.sv
module skey_guard_chk #(
  parameter int ADDR_W      = 20,
  parameter int BLK_LSB     = 11,
  parameter int IDX_W       = 6,
  parameter int PSW_W       = 16,
  parameter int PSW_KEY_LSB = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [PSW_W-1:0]  req_psw,
  input logic              rsp_valid,
  input logic              rsp_grant,
  input logic [1:0]        rsp_err,
  input logic              mem_we,
  input logic              op_valid,
  input logic              op_super,
  input logic              op_ack,
  input logic [1:0]        op_err,
  input logic [3:0]        op_key_out
);
  localparam int HI_LSB = BLK_LSB + IDX_W;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic hi_bad;
  assign hi_bad = (req_addr >> HI_LSB) != '0;

  assert_we_needs_grant_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (rsp_valid && rsp_grant && rsp_err == 2'd0));

  assert_rsp_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (rsp_valid == $past(req_valid)));

  assert_op_one_cycle_R12: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (op_ack == $past(op_valid)));

  assert_range_error_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && hi_bad)) |-> (rsp_err == 2'd2 && !rsp_grant && !mem_we));

  assert_zero_key_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(req_valid && !hi_bad && req_psw[PSW_KEY_LSB +: 4] == 4'd0)) |-> rsp_grant);

  assert_user_op_refused_R10: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(op_valid && !op_super)) |-> (op_err == 2'd3 && op_key_out == 4'd0));
endmodule

bind skey_guard skey_guard_chk #(
  .ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB), .IDX_W(IDX_W),
  .PSW_W(PSW_W), .PSW_KEY_LSB(PSW_KEY_LSB)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_psw(req_psw), .rsp_valid(rsp_valid),
  .rsp_grant(rsp_grant), .rsp_err(rsp_err), .mem_we(mem_we),
  .op_valid(op_valid), .op_super(op_super), .op_ack(op_ack),
  .op_err(op_err), .op_key_out(op_key_out)
);

// File: tb/skey_guard_tb_top.sv
module skey_guard_tb_top;
  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [15:0]       req_psw;
  logic              rsp_valid, rsp_grant, mem_we;
  logic [1:0]        rsp_err;
  logic              op_valid, op_set, op_super, op_fetch_prot;
  logic [ADDR_W-1:0] op_addr;
  logic [3:0]        op_key;
  logic              op_ack, op_fetch_prot_out;
  logic [1:0]        op_err;
  logic [3:0]        op_key_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  skey_guard dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_psw(req_psw),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err), .mem_we(mem_we),
    .op_valid(op_valid), .op_set(op_set), .op_super(op_super), .op_addr(op_addr),
    .op_key(op_key), .op_fetch_prot(op_fetch_prot),
    .op_ack(op_ack), .op_err(op_err), .op_key_out(op_key_out),
    .op_fetch_prot_out(op_fetch_prot_out)
  );

  function automatic logic [ADDR_W-1:0] blk_addr(int blk, int off);
    return ADDR_W'(blk * 2048 + off);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Issue one request; results are sampled at the next falling edge.
  task automatic do_req(logic wr, logic [ADDR_W-1:0] a, logic [15:0] psw,
                        output logic g, output logic [1:0] e, output logic we);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_psw = psw;
    @(negedge clk);
    g = rsp_grant; e = rsp_err; we = mem_we;
    req_valid = 1'b0;
  endtask

  task automatic do_op(logic set, logic sup, logic [ADDR_W-1:0] a, logic [3:0] k, logic fp,
                       output logic [1:0] e, output logic [3:0] ko, output logic fo);
    @(negedge clk);
    op_valid = 1'b1; op_set = set; op_super = sup; op_addr = a; op_key = k; op_fetch_prot = fp;
    @(negedge clk);
    e = op_err; ko = op_key_out; fo = op_fetch_prot_out;
    op_valid = 1'b0;
  endtask

  function automatic logic [15:0] psw_of(logic [3:0] k);
    return {4'h0, k, 8'h00};
  endfunction

  task automatic t_reset;
    logic g, we, fo; logic [1:0] e; logic [3:0] ko;
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "mem_we", mem_we, 0);
    chk("R1", "op_ack", op_ack, 0);
    do_op(1'b0, 1'b1, blk_addr(5, 0), 4'd0, 1'b0, e, ko, fo);
    chk("R1", "insert key", ko, 0);
    chk("R1", "insert fp", fo, 0);
    do_req(1'b1, blk_addr(5, 100), psw_of(4'd7), g, e, we);
    chk("R3", "store to untagged block grant", g, 1);
  endtask

  task automatic t_set_insert;
    logic fo; logic [1:0] e; logic [3:0] ko;
    do_op(1'b1, 1'b1, blk_addr(3, 0), 4'd6, 1'b0, e, ko, fo);
    chk("R11", "set err", e, 0);
    do_op(1'b0, 1'b1, blk_addr(3, 12), 4'd0, 1'b0, e, ko, fo);
    chk("R11", "insert key", ko, 6);
    chk("R11", "insert fp", fo, 0);
  endtask

  task automatic t_compare;
    logic g, we; logic [1:0] e;
    do_req(1'b1, blk_addr(3, 8), psw_of(4'd6), g, e, we);
    chk("R2", "equal grant", g, 1);
    chk("R2", "equal mem_we", we, 1);
    chk("R2", "equal err", e, 0);
    do_req(1'b1, blk_addr(3, 8), psw_of(4'd5), g, e, we);
    chk("R4", "mismatch grant", g, 0);
    chk("R4", "mismatch err", e, 1);
    chk("R4", "mismatch mem_we", we, 0);
    do_req(1'b1, blk_addr(3, 8), psw_of(4'd0), g, e, we);
    chk("R3", "zero access key grant", g, 1);
  endtask

  task automatic t_psw_field;
    logic g, we; logic [1:0] e;
    do_req(1'b1, blk_addr(3, 0), 16'hF6FF, g, e, we);
    chk("R7", "key 6 with junk bits grant", g, 1);
    do_req(1'b1, blk_addr(3, 0), 16'hF5FF, g, e, we);
    chk("R7", "key 5 with junk bits err", e, 1);
  endtask

  task automatic t_fetch;
    logic g, we, fo; logic [1:0] e; logic [3:0] ko;
    do_req(1'b0, blk_addr(3, 0), psw_of(4'd5), g, e, we);
    chk("R5", "read no fp grant", g, 1);
    chk("R5", "read mem_we", we, 0);
    do_op(1'b1, 1'b1, blk_addr(3, 0), 4'd6, 1'b1, e, ko, fo);
    do_req(1'b0, blk_addr(3, 0), psw_of(4'd5), g, e, we);
    chk("R6", "read fp mismatch err", e, 1);
    do_req(1'b0, blk_addr(3, 0), psw_of(4'd6), g, e, we);
    chk("R6", "read fp match grant", g, 1);
    chk("R6", "read fp match mem_we", we, 0);
  endtask

  task automatic t_granule;
    logic g, we, fo; logic [1:0] e; logic [3:0] ko;
    do_op(1'b1, 1'b1, blk_addr(9, 0), 4'd2, 1'b0, e, ko, fo);
    do_req(1'b1, blk_addr(9, 2047), psw_of(4'd3), g, e, we);
    chk("R8", "last byte of block 9 err", e, 1);
    do_req(1'b1, blk_addr(9, 0), psw_of(4'd2), g, e, we);
    chk("R8", "first byte of block 9 grant", g, 1);
    do_req(1'b1, blk_addr(10, 0), psw_of(4'd3), g, e, we);
    chk("R8", "first byte of block 10 grant", g, 1);
  endtask

  task automatic t_range;
    logic g, we, fo; logic [1:0] e; logic [3:0] ko;
    do_req(1'b1, ADDR_W'(1 << 17), psw_of(4'd0), g, e, we);
    chk("R9", "out of range err", e, 2);
    chk("R9", "out of range mem_we", we, 0);
    do_op(1'b1, 1'b1, ADDR_W'(1 << 17), 4'd9, 1'b1, e, ko, fo);
    chk("R9", "set out of range err", e, 2);
    do_op(1'b0, 1'b1, blk_addr(0, 0), 4'd0, 1'b0, e, ko, fo);
    chk("R9", "block 0 untouched key", ko, 0);
    chk("R9", "block 0 untouched fp", fo, 0);
  endtask

  task automatic t_priv;
    logic fo; logic [1:0] e; logic [3:0] ko;
    do_op(1'b1, 1'b0, blk_addr(3, 0), 4'd9, 1'b0, e, ko, fo);
    chk("R10", "user set err", e, 3);
    do_op(1'b0, 1'b1, blk_addr(3, 0), 4'd0, 1'b0, e, ko, fo);
    chk("R10", "array unchanged key", ko, 6);
    chk("R10", "array unchanged fp", fo, 1);
    do_op(1'b0, 1'b0, blk_addr(3, 0), 4'd0, 1'b0, e, ko, fo);
    chk("R10", "user insert err", e, 3);
    chk("R10", "user insert data", ko, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = blk_addr(4, 0); req_psw = psw_of(4'd1);
    chk("R12", "no response before edge", rsp_valid, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12", "response after one edge", rsp_valid, 1);
    @(negedge clk);
    chk("R12", "response pulse ends", rsp_valid, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_psw = '0;
    op_valid = 1'b0; op_set = 1'b0; op_super = 1'b0; op_addr = '0; op_key = '0;
    op_fetch_prot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set_insert();
    t_compare();
    t_psw_field();
    t_fetch();
    t_granule();
    t_range();
    t_priv();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule